// File: doc/BRIEF.md
# JTAG Debug Port Access Logic

This block is the target side of a JTAG debug port. A standard 16-state TAP controller and a 4-bit instruction register choose one of four data registers: abort, debug-port access, access-port access and the identification code. Any other instruction code selects a 1-bit bypass register. An access scan is 35 bits long. It holds a 3-bit header, made of a two-bit register address and a read/not-write bit, followed by 32 data bits. The header field returns an acknowledge code: OK/FAULT when the port is free and WAIT while an access-port transaction is still in flight.

Reads are posted. The data captured by a scan is the result of the most recent completed read, and software collects it with a later scan, usually a read of the read buffer. The port holds three registers of its own: control/status, bank select and the read buffer. Access-port operations go out on a valid/ready request channel, using the bank held in select, and a response channel returns read data and an error bit. Sticky overrun and error flags block further access-port traffic until software clears them. An abort command cancels a transaction that has stalled.

Top module: `jtag_dbg_port`

## Requirements
- R1: The instruction register is 4 bits wide, shifts LSB first and captures 4'b0001. Test-logic-reset loads the identification code instruction 4'hE, whose 32-bit data register captures the IDCODE_VAL parameter. Any code not named in R2 selects a 1-bit bypass register that captures 0.
- R2: Instruction 4'hA selects debug-port access, 4'hB access-port access and 4'h8 abort. Each of these data registers is 35 bits, shifted LSB first: bit 0 is RnW (1 = read), bits 2:1 are the register address A, and bits 34:3 are the data.
- R3: The 3 header bits captured in an access scan read 3'b010 (OK/FAULT) when no access-port transaction is outstanding and 3'b001 (WAIT) while one is outstanding.
- R4: Read data is posted. The 32 data bits captured are the read buffer. A debug-port read of control/status (A=1) or select (A=2) loads the buffer at once. An access-port read loads the buffer when its response arrives.
- R5: A debug-port read of the read buffer (A=3) returns it unchanged and has no other effect. A write to A=3 is ignored.
- R6: A scan that captured WAIT is discarded: no register write and no access-port request. If overrun detection (control/status bit 0) is set, such a scan sets the sticky overrun flag (bit 1).
- R7: An access-port scan issues a request with address {select[7:4], A, 2'b00}, write = !RnW, and the scan data. Valid is held until ready. A response with the error bit set raises the sticky error flag (control/status bit 5).
- R8: While the sticky overrun or sticky error flag is set, access-port scans issue no request.
- R9: A control/status write clears bits 1 and 5 where the data bit is 1 and loads bit 0, bit 28 (debug power request) and bit 30 (system power request). The acknowledges in bits 29 and 31 follow their requests one cycle later.
- R10: An abort scan whose data field equals exactly 1 ends the outstanding transaction, pulses apAbort for one cycle, and makes the next scan return OK/FAULT. Any other data value has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out (0 outside shift states) |
| apReqValid | output | 1 | Access-port request valid |
| apReqReady | input | 1 | Access-port request accepted |
| apReqWrite | output | 1 | Request is a write |
| apReqAddr | output | 8 | Access-port register address |
| apReqData | output | 32 | Write data |
| apAbort | output | 1 | One-cycle cancel of the outstanding transaction |
| apRspValid | input | 1 | Response strobe |
| apRspData | input | 32 | Read response data |
| apRspErr | input | 1 | Response carries an error |

## Verification
Access scans are run in three settings: with the access port idle, with a long response latency so that a following scan sees WAIT, and with an erroring bank. Comparing these shows that the acknowledge code tracks the outstanding transaction, and that posted data arrives only once the response has come back. Discarded writes are exposed by reading select and control/status back through the read buffer. Suppressed access-port writes are exposed by the bank model's write counter. Abort scans with data values 2 and 1 are compared to show that only the exact value cancels the transaction.

// File: rtl/jdp_pkg.sv
package jdp_pkg;
  localparam int DATA_W = 32;
  localparam int HDR_W  = 3;
  localparam int ACC_W  = DATA_W + HDR_W;
  localparam int IR_W   = 4;
  localparam int BANK_W = 4;
  localparam int AP_ADDR_W = BANK_W + 4;

  localparam logic [IR_W-1:0] IR_ABORT  = 4'h8;
  localparam logic [IR_W-1:0] IR_DPACC  = 4'hA;
  localparam logic [IR_W-1:0] IR_APACC  = 4'hB;
  localparam logic [IR_W-1:0] IR_IDCODE = 4'hE;

  localparam logic [HDR_W-1:0] ACK_OK   = 3'b010;
  localparam logic [HDR_W-1:0] ACK_WAIT = 3'b001;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SH_DR, EX1_DR, PA_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SH_IR, EX1_IR, PA_IR, EX2_IR, UPD_IR
  } tapState_e;

  typedef enum logic [1:0] { DR_BYP, DR_IDC, DR_ACC } drSel_e;

  typedef struct packed {
    logic             capDr;
    logic             shiftDr;
    drSel_e           drSel;
    logic [HDR_W-1:0] ack;
    logic             dpRd;
    logic             dpWr;
    logic             apIssue;
    logic             setOrun;
    logic             rspTake;
  } dpStrobe_t;

  typedef struct packed {
    logic stickyAny;
    logic orunDetect;
    logic hdrRead;
    logic abortOne;
  } dpStatus_t;
endpackage

// File: rtl/jdp_ctrl.sv
module jdp_ctrl
  import jdp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tms,
  input  logic      tdi,
  input  logic      drOut,
  input  dpStatus_t st,
  output dpStrobe_t str,
  output logic      tdo,
  output logic      apReqValid,
  input  logic      apReqReady,
  input  logic      apRspValid,
  output logic      apAbort
);
  tapState_e tapState, tapNext;
  logic [IR_W-1:0] ir, irShift;
  logic busy, waitScan, updDr, abortHit, isAccIr;

  always_comb begin
    unique case (tapState)
      TLR:     tapNext = tms ? TLR    : RTI;
      RTI:     tapNext = tms ? SEL_DR : RTI;
      SEL_DR:  tapNext = tms ? SEL_IR : CAP_DR;
      CAP_DR:  tapNext = tms ? EX1_DR : SH_DR;
      SH_DR:   tapNext = tms ? EX1_DR : SH_DR;
      EX1_DR:  tapNext = tms ? UPD_DR : PA_DR;
      PA_DR:   tapNext = tms ? EX2_DR : PA_DR;
      EX2_DR:  tapNext = tms ? UPD_DR : SH_DR;
      UPD_DR:  tapNext = tms ? SEL_DR : RTI;
      SEL_IR:  tapNext = tms ? TLR    : CAP_IR;
      CAP_IR:  tapNext = tms ? EX1_IR : SH_IR;
      SH_IR:   tapNext = tms ? EX1_IR : SH_IR;
      EX1_IR:  tapNext = tms ? UPD_IR : PA_IR;
      PA_IR:   tapNext = tms ? EX2_IR : PA_IR;
      EX2_IR:  tapNext = tms ? UPD_IR : SH_IR;
      default: tapNext = tms ? SEL_DR : RTI;
    endcase
  end

  assign updDr    = (tapState == UPD_DR);
  assign isAccIr  = (ir == IR_DPACC) || (ir == IR_APACC);
  assign abortHit = updDr && (ir == IR_ABORT) && st.abortOne;

  always_comb begin
    str = '0;
    unique case (ir)
      IR_DPACC, IR_APACC, IR_ABORT: str.drSel = DR_ACC;
      IR_IDCODE:                    str.drSel = DR_IDC;
      default:                      str.drSel = DR_BYP;
    endcase
    str.capDr   = (tapState == CAP_DR);
    str.shiftDr = (tapState == SH_DR);
    str.ack     = busy ? ACK_WAIT : ACK_OK;
    str.dpRd    = updDr && (ir == IR_DPACC) && !waitScan && st.hdrRead;
    str.dpWr    = updDr && (ir == IR_DPACC) && !waitScan && !st.hdrRead;
    str.apIssue = updDr && (ir == IR_APACC) && !waitScan && !st.stickyAny;
    str.setOrun = updDr && isAccIr && waitScan && st.orunDetect;
    str.rspTake = apRspValid && busy && !abortHit;
  end

  always_comb begin
    if (tapState == SH_IR)      tdo = irShift[0];
    else if (tapState == SH_DR) tdo = drOut;
    else                        tdo = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapState   <= TLR;
      ir         <= IR_IDCODE;
      irShift    <= '0;
      busy       <= 1'b0;
      waitScan   <= 1'b0;
      apReqValid <= 1'b0;
      apAbort    <= 1'b0;
    end else begin
      tapState <= tapNext;
      apAbort  <= abortHit;
      if (tapState == TLR)         ir <= IR_IDCODE;
      else if (tapState == UPD_IR) ir <= irShift;
      if (tapState == CAP_IR)      irShift <= {{(IR_W-1){1'b0}}, 1'b1};
      else if (tapState == SH_IR)  irShift <= {tdi, irShift[IR_W-1:1]};
      if (str.capDr) waitScan <= busy;
      if (abortHit)         busy <= 1'b0;
      else if (str.apIssue) busy <= 1'b1;
      else if (str.rspTake) busy <= 1'b0;
      if (abortHit)                      apReqValid <= 1'b0;
      else if (str.apIssue)              apReqValid <= 1'b1;
      else if (apReqValid && apReqReady) apReqValid <= 1'b0;
    end
  end

  // R1
  tlr_loads_idcode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tapState == TLR) |=> (ir == IR_IDCODE));
  // R10
  abort_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    abortHit |=> (!busy && !apReqValid && apAbort));
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (apReqValid && !apReqReady && !abortHit) |=> apReqValid);
  // R8
  no_issue_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(apReqValid) |-> !$past(st.stickyAny));
  // R3
  wait_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (str.capDr && apReqValid) |-> (str.ack == ACK_WAIT));
endmodule

// File: rtl/jdp_dpath.sv
module jdp_dpath
  import jdp_pkg::*;
#(
  parameter logic [DATA_W-1:0] IDCODE_VAL = 32'h0A5C_1001
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tdi,
  input  dpStrobe_t            str,
  input  logic [DATA_W-1:0]    apRspData,
  input  logic                 apRspErr,
  output logic                 drOut,
  output dpStatus_t            st,
  output logic                 apReqWrite,
  output logic [AP_ADDR_W-1:0] apReqAddr,
  output logic [DATA_W-1:0]    apReqData
);
  localparam int PAD_W = ACC_W - DATA_W;

  logic [ACC_W-1:0]  shiftReg;
  logic [DATA_W-1:0] rdBuf, selectReg, wrData, ctrlStatVal;
  logic [1:0]        hdrA;
  logic orunDetect, stickyOrun, stickyErr;
  logic dbgReq, dbgAck, sysReq, sysAck;

  assign hdrA   = shiftReg[2:1];
  assign wrData = shiftReg[ACC_W-1:HDR_W];
  assign drOut  = shiftReg[0];
  assign ctrlStatVal = {sysAck, sysReq, dbgAck, dbgReq, 22'd0,
                        stickyErr, 3'd0, stickyOrun, orunDetect};

  assign st.stickyAny  = stickyOrun || stickyErr;
  assign st.orunDetect = orunDetect;
  assign st.hdrRead    = shiftReg[0];
  assign st.abortOne   = (wrData == {{(DATA_W-1){1'b0}}, 1'b1});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      rdBuf      <= '0;
      selectReg  <= '0;
      orunDetect <= 1'b0;
      stickyOrun <= 1'b0;
      stickyErr  <= 1'b0;
      dbgReq     <= 1'b0;
      dbgAck     <= 1'b0;
      sysReq     <= 1'b0;
      sysAck     <= 1'b0;
      apReqWrite <= 1'b0;
      apReqAddr  <= '0;
      apReqData  <= '0;
    end else begin
      dbgAck <= dbgReq;
      sysAck <= sysReq;
      if (str.capDr) begin
        unique case (str.drSel)
          DR_ACC:  shiftReg <= {rdBuf, str.ack};
          DR_IDC:  shiftReg <= {{PAD_W{1'b0}}, IDCODE_VAL};
          default: shiftReg <= '0;
        endcase
      end else if (str.shiftDr) begin
        unique case (str.drSel)
          DR_ACC:  shiftReg <= {tdi, shiftReg[ACC_W-1:1]};
          DR_IDC:  shiftReg <= {{PAD_W{1'b0}}, tdi, shiftReg[DATA_W-1:1]};
          default: shiftReg <= {{(ACC_W-1){1'b0}}, tdi};
        endcase
      end
      if (str.dpRd) begin
        unique case (hdrA)
          2'd1:    rdBuf <= ctrlStatVal;
          2'd2:    rdBuf <= selectReg;
          2'd3:    rdBuf <= rdBuf;
          default: rdBuf <= '0;
        endcase
      end
      if (str.dpWr) begin
        if (hdrA == 2'd1) begin
          orunDetect <= wrData[0];
          dbgReq     <= wrData[28];
          sysReq     <= wrData[30];
          if (wrData[1]) stickyOrun <= 1'b0;
          if (wrData[5]) stickyErr  <= 1'b0;
        end else if (hdrA == 2'd2) begin
          selectReg <= wrData;
        end
      end
      if (str.setOrun) stickyOrun <= 1'b1;
      if (str.rspTake) begin
        if (!apReqWrite) rdBuf <= apRspData;
        if (apRspErr) stickyErr <= 1'b1;
      end
      if (str.apIssue) begin
        apReqAddr  <= {selectReg[7:4], hdrA, 2'b00};
        apReqData  <= wrData;
        apReqWrite <= !shiftReg[0];
      end
    end
  end

  // R5
  rdbuf_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!str.dpRd && !str.rspTake) |=> $stable(rdBuf));
  // R6
  orun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    str.setOrun |=> stickyOrun);
  // R6
  wait_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!str.dpWr) |=> $stable(selectReg));
endmodule

// File: rtl/jtag_dbg_port.sv
module jtag_dbg_port
  import jdp_pkg::*;
#(
  parameter logic [31:0] IDCODE_VAL = 32'h0A5C_1001
)(
  input  logic        tck,
  input  logic        rstN,
  input  logic        tms,
  input  logic        tdi,
  output logic        tdo,
  output logic        apReqValid,
  input  logic        apReqReady,
  output logic        apReqWrite,
  output logic [7:0]  apReqAddr,
  output logic [31:0] apReqData,
  output logic        apAbort,
  input  logic        apRspValid,
  input  logic [31:0] apRspData,
  input  logic        apRspErr
);
  dpStrobe_t str;
  dpStatus_t st;
  logic drOut;

  jdp_ctrl u_ctrl (
    .clk(tck), .rstN(rstN), .tms(tms), .tdi(tdi), .drOut(drOut),
    .st(st), .str(str), .tdo(tdo), .apReqValid(apReqValid),
    .apReqReady(apReqReady), .apRspValid(apRspValid), .apAbort(apAbort)
  );

  jdp_dpath #(.IDCODE_VAL(IDCODE_VAL)) u_dpath (
    .clk(tck), .rstN(rstN), .tdi(tdi), .str(str),
    .apRspData(apRspData), .apRspErr(apRspErr), .drOut(drOut), .st(st),
    .apReqWrite(apReqWrite), .apReqAddr(apReqAddr), .apReqData(apReqData)
  );
endmodule

// File: tb/jtag_dbg_port_bench.sv
module jtag_dbg_port_bench;
  localparam logic [31:0] IDV = 32'h0A5C_1001;
  localparam logic [2:0] OK = 3'b010, WT = 3'b001;

  logic tck = 1'b0, rstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, apReqValid, apReqWrite, apAbort;
  logic apReqReady = 1'b1, apRspValid = 1'b0, apRspErr = 1'b0;
  logic [7:0] apReqAddr;
  logic [31:0] apReqData, apRspData = '0;

  always #5 tck = ~tck;

  jtag_dbg_port #(.IDCODE_VAL(IDV)) u_jtag_dbg_port (
    .tck(tck), .rstN(rstN), .tms(tms), .tdi(tdi), .tdo(tdo),
    .apReqValid(apReqValid), .apReqReady(apReqReady), .apReqWrite(apReqWrite),
    .apReqAddr(apReqAddr), .apReqData(apReqData), .apAbort(apAbort),
    .apRspValid(apRspValid), .apRspData(apRspData), .apRspErr(apRspErr)
  );

  int vectors = 0, miscompares = 0;

  // access-port model: register bank with programmable latency
  logic [31:0] apMem [0:63];
  int apLat = 0, apCnt = 0, apWrites = 0, abortSeen = 0;
  logic apPend = 1'b0;
  logic [7:0] lastAddr = '0;
  initial for (int i = 0; i < 64; i++) apMem[i] = '0;

  always @(posedge tck) begin
    apRspValid <= 1'b0;
    if (apAbort) begin
      apPend <= 1'b0;
      abortSeen <= abortSeen + 1;
    end else if (apPend) begin
      if (apCnt == 0) begin apRspValid <= 1'b1; apPend <= 1'b0; end
      else apCnt <= apCnt - 1;
    end else if (apReqValid && apReqReady) begin
      apPend   <= 1'b1;
      apCnt    <= apLat;
      lastAddr <= apReqAddr;
      apRspErr <= (apReqAddr[7:4] == 4'hF);
      apRspData <= apMem[apReqAddr[7:2]];
      if (apReqWrite && apReqAddr[7:4] != 4'hF) begin
        apMem[apReqAddr[7:2]] <= apReqData;
        apWrites <= apWrites + 1;
      end
    end
  end

  // scoreboard
  typedef struct { string req; logic [2:0] ack; logic [31:0] data; logic chkData; } exp_t;
  exp_t expQ[$];
  logic [2:0] obsAck;
  logic [31:0] obsData;
  event scanDone;

  task automatic expectScan(input string req, input logic [2:0] ack,
                            input logic [31:0] data, input logic chkData);
    exp_t e;
    e.req = req; e.ack = ack; e.data = data; e.chkData = chkData;
    expQ.push_back(e);
  endtask

  initial forever begin
    exp_t e;
    @(scanDone);
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      vectors++;
      if (obsAck !== e.ack || (e.chkData && obsData !== e.data)) begin
        miscompares++;
        $display("FAIL %s: ack=%b data=%h expected ack=%b data=%h", e.req,
                 obsAck, obsData, e.ack, e.data);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clk1(input logic m, input logic d, output logic o);
    @(negedge tck);
    o = tdo; tms = m; tdi = d;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) clk1(1'b0, 1'b0, o);
  endtask

  task automatic tapReset();
    logic o;
    for (int i = 0; i < 6; i++) clk1(1'b1, 1'b0, o);
    clk1(1'b0, 1'b0, o);
  endtask

  task automatic irScan(input logic [3:0] code, output logic [3:0] cap);
    logic o;
    clk1(1'b1, 1'b0, o); clk1(1'b1, 1'b0, o);
    clk1(1'b0, 1'b0, o); clk1(1'b0, 1'b0, o);
    for (int i = 0; i < 4; i++) begin clk1(i == 3, code[i], o); cap[i] = o; end
    clk1(1'b1, 1'b0, o); clk1(1'b0, 1'b0, o);
  endtask

  task automatic ir(input logic [3:0] code);
    logic [3:0] c;
    irScan(code, c);
  endtask

  task automatic drScan(input int n, input logic [34:0] din, output logic [34:0] dout);
    logic o;
    dout = '0;
    clk1(1'b1, 1'b0, o); clk1(1'b0, 1'b0, o); clk1(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin clk1(i == n - 1, din[i], o); dout[i] = o; end
    clk1(1'b1, 1'b0, o); clk1(1'b0, 1'b0, o);
  endtask

  task automatic acc(input logic [1:0] a, input logic rnw, input logic [31:0] d);
    logic [34:0] r;
    drScan(35, {d, a, rnw}, r);
    obsAck = r[2:0]; obsData = r[34:3];
    -> scanDone;
    idle(1);
  endtask

  initial begin
    repeat (150000) @(posedge tck);
    miscompares++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [34:0] r;
    logic [3:0] c;
    int wr0;
    repeat (3) @(negedge tck);
    chk("R7 reset valid", {31'd0, apReqValid}, 32'd0);
    chk("R10 reset abort", {31'd0, apAbort}, 32'd0);
    rstN = 1'b1;
    tapReset();
    // R1: IDCODE selected after reset, IR capture pattern, bypass
    drScan(32, 35'd0, r);
    chk("R1 idcode", r[31:0], IDV);
    irScan(4'hE, c);
    chk("R1 ir capture", {28'd0, c}, 32'd1);
    ir(4'h3);
    drScan(2, 35'b11, r);
    chk("R1 bypass", {30'd0, r[1:0]}, 32'd2);
    // R2/R4/R5: DP select write, posted read, RDBUFF
    ir(4'hA);
    expectScan("R2 first scan", OK, 32'd0, 1'b1);
    acc(2'd2, 1'b0, 32'h30);
    expectScan("R3 ok idle", OK, 32'd0, 1'b0);
    acc(2'd2, 1'b1, 32'd0);
    expectScan("R4 select posted", OK, 32'h30, 1'b1);
    acc(2'd3, 1'b1, 32'd0);
    acc(2'd3, 1'b0, 32'h1234);
    expectScan("R5 rdbuff no effect", OK, 32'h30, 1'b1);
    acc(2'd3, 1'b1, 32'd0);
    // R7/R4: AP write then AP read
    apLat = 0;
    ir(4'hB);
    acc(2'd1, 1'b0, 32'hCAFE_0001);
    idle(5);
    chk("R7 ap addr", {24'd0, lastAddr}, 32'h34);
    chk("R7 ap write data", apMem[13], 32'hCAFE_0001);
    acc(2'd1, 1'b1, 32'd0);
    ir(4'hA);
    expectScan("R4 ap read posted", OK, 32'hCAFE_0001, 1'b1);
    acc(2'd3, 1'b1, 32'd0);
    // R3/R6: WAIT without overrun detection
    apLat = 300;
    ir(4'hB);
    acc(2'd1, 1'b1, 32'd0);
    ir(4'hA);
    expectScan("R3 wait", WT, 32'd0, 1'b0);
    acc(2'd2, 1'b0, 32'h50);
    idle(400);
    expectScan("R4 late ap data", OK, 32'hCAFE_0001, 1'b1);
    acc(2'd1, 1'b1, 32'd0);
    expectScan("R6 no sticky", OK, 32'd0, 1'b1);
    acc(2'd2, 1'b1, 32'd0);
    expectScan("R6 write discarded", OK, 32'h30, 1'b1);
    acc(2'd3, 1'b1, 32'd0);
    // R9: power requests and overrun detect
    acc(2'd1, 1'b0, 32'h5000_0001);
    acc(2'd1, 1'b1, 32'd0);
    expectScan("R9 power acks", OK, 32'hF000_0001, 1'b1);
    acc(2'd3, 1'b1, 32'd0);
    // R6: overrun sets sticky flag
    ir(4'hB);
    acc(2'd1, 1'b0, 32'h1111_1111);
    ir(4'hA);
    expectScan("R6 wait orun", WT, 32'd0, 1'b0);
    acc(2'd2, 1'b0, 32'h70);
    idle(400);
    acc(2'd1, 1'b1, 32'd0);
    expectScan("R6 sticky orun", OK, 32'hF000_0003, 1'b1);
    acc(2'd3, 1'b1, 32'd0);
    // R8: AP traffic blocked while sticky
    wr0 = apWrites;
    ir(4'hB);
    acc(2'd1, 1'b0, 32'h2222_2222);
    idle(20);
    chk("R8 no request", apWrites, wr0);
    chk("R8 bank untouched", apMem[13], 32'h1111_1111);
    // R9: write-one-to-clear
    ir(4'hA);
    acc(2'd1, 1'b0, 32'h5000_0023);
    acc(2'd1, 1'b1, 32'd0);
    expectScan("R9 cleared", OK, 32'hF000_0001, 1'b1);
    acc(2'd3, 1'b1, 32'd0);
    // R7: error response raises sticky error
    apLat = 0;
    acc(2'd2, 1'b0, 32'hF0);
    ir(4'hB);
    acc(2'd0, 1'b0, 32'd5);
    idle(5);
    ir(4'hA);
    acc(2'd1, 1'b1, 32'd0);
    expectScan("R7 sticky err", OK, 32'hF000_0021, 1'b1);
    acc(2'd3, 1'b1, 32'd0);
    acc(2'd1, 1'b0, 32'h5000_0022);
    acc(2'd2, 1'b0, 32'h30);
    acc(2'd1, 1'b1, 32'd0);
    expectScan("R9 err cleared", OK, 32'hF000_0000, 1'b1);
    acc(2'd3, 1'b1, 32'd0);
    // R10: abort
    apLat = 3000;
    ir(4'hB);
    acc(2'd1, 1'b1, 32'd0);
    ir(4'h8);
    expectScan("R10 abort value 2 ignored", WT, 32'd0, 1'b0);
    acc(2'd0, 1'b0, 32'd2);
    expectScan("R10 still busy", WT, 32'd0, 1'b0);
    acc(2'd0, 1'b0, 32'd1);
    ir(4'hA);
    expectScan("R10 ok after abort", OK, 32'd0, 1'b0);
    acc(2'd3, 1'b1, 32'd0);
    chk("R10 abort pulse", abortSeen, 1);
    idle(3100);
    chk("R10 no late response", {31'd0, apPend}, 32'd0);
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule